// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block keeps the interrupt state of one core across a 256-entry vector space. It uses three one-bit-per-vector maps. The request map marks vectors waiting for service. The in-service map marks vectors the core has taken and not yet retired. The trigger map marks pending vectors that were raised as level-sensitive. A single external-interrupt slot sits beside the maps and carries its own 8-bit priority, which is also the vector it returns. A task-priority register and a spurious-vector register with a software enable complete the state.

Whenever an eligible vector exists, or the external slot is full, the block raises a request line to the core. The core answers with a one-cycle acknowledge request. One cycle later it receives a vector: the winning local vector, the external slot's vector, or the spurious vector. A write to the end-of-interrupt input retires the highest in-service vector. Level-sensitive vectors produce an end-of-interrupt broadcast strobe with the vector, so that the sources feeding the controller can re-arm.

Top module: `vec_prio_ctrl`

## Requirements
- R1: A request on `setValid` sets the request bit of `setVector`. The same event sets the trigger bit of that vector when `setLevel` is 1 (level) and clears it when `setLevel` is 0 (edge).
- R2: A pending vector is eligible only if it is the highest pending vector, is strictly greater than the highest in-service vector (any vector qualifies when nothing is in service), and is greater than or equal to the 8-bit task priority. This holds at every group boundary of the search, vectors 0x00 and 0xFF included.
- R3: `irqOut` is 1 when the external slot is pending. It is also 1 when `globalEn` and the software enable are both 1 and an eligible vector exists. It reflects a state change right after the clock edge that made it.
- R4: An `ackReq` held for one cycle yields `ackValid` high for exactly the next cycle, with the vector on `ackVector`.
- R5: When no vector is eligible and the external slot is empty, an acknowledge returns the spurious vector.
- R6: On acknowledge, the local vector wins only if the external slot is empty or its priority is numerically lower than the eligible vector. Otherwise the slot is emptied and its priority value is returned.
- R7: Acknowledging a local vector clears its request bit and sets its in-service bit. That blocks the vector itself and all lower vectors until an end-of-interrupt.
- R8: Acknowledging a local vector whose trigger bit is set clears that bit and raises `eoiBcastValid` in the same cycle as `ackValid`, with the vector on `eoiBcastVector`. An edge vector gives no broadcast.
- R9: An `eoiWrite` clears the highest set in-service bit and then re-evaluates eligibility. If that vector's trigger bit is set, `eoiNotifyValid` is high for the next cycle with the vector on `eoiNotifyVector`. An `eoiWrite` with nothing in service has no effect.
- R10: `tprWe` loads the full 8-bit task priority. `tprNibWe` loads `tprNib` shifted left by 4 and takes precedence over `tprWe`. `tprNibOut` always shows the register shifted right by 4.
- R11: After reset all maps are clear, the external slot is empty, the task priority is 0, the spurious vector is 0xFF and the software enable is 0.
- R12: If a new request for a vector coincides with that vector's local acknowledge, the request survives. The vector is pending again once it leaves service.
- R13: The acknowledge decision does not depend on `globalEn` or the software enable. An eligible vector is returned even while `irqOut` is held low by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| globalEn | input | 1 | Global enable for local vectors on `irqOut` |
| setValid | input | 1 | Vector request strobe |
| setVector | input | 8 | Requested vector |
| setLevel | input | 1 | 1 = level-sensitive, 0 = edge |
| extValid | input | 1 | Fill the external-interrupt slot |
| extVector | input | 8 | External slot priority and vector |
| tprWe | input | 1 | Full task-priority write strobe |
| tprData | input | 8 | Full task-priority value |
| tprNibWe | input | 1 | Nibble task-priority write strobe |
| tprNib | input | 4 | Nibble task-priority value |
| tprNibOut | output | 4 | Task priority shifted right by 4 |
| svWe | input | 1 | Spurious/enable register write strobe |
| svEnable | input | 1 | Software enable value |
| svVector | input | 8 | Spurious vector value |
| ackReq | input | 1 | Interrupt acknowledge request |
| ackValid | output | 1 | Acknowledge result valid |
| ackVector | output | 8 | Acknowledged vector |
| eoiWrite | input | 1 | End-of-interrupt write |
| irqOut | output | 1 | Interrupt request to the core |
| eoiBcastValid | output | 1 | Broadcast strobe for an acknowledged level vector |
| eoiBcastVector | output | 8 | Vector carried by the broadcast |
| eoiNotifyValid | output | 1 | Notification strobe for a retired level vector |
| eoiNotifyVector | output | 8 | Vector carried by the notification |

## Verification
A corrupted request or in-service map shows up first on `irqOut`, right after the edge that wrote the bad value, as a line that is high or low against the eligibility rule. It shows up at the latest on the next acknowledge, as a wrong vector, a repeated vector or an unexpected spurious return. A stale or wrong trigger bit appears only as a missing or extra broadcast or notification strobe, so the tests pair every level or edge request with its acknowledge and end-of-interrupt. A wrong in-service ordering hides until an end-of-interrupt retires the wrong vector. The nested scenarios therefore check `irqOut` after each retirement.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

  // Strobes that control hands to the datapath for the coming edge.
  typedef struct packed {
    logic ackLocal;  // retire the highest pending vector into service
    logic ackExt;    // empty the external slot
    logic eoiPop;    // clear the highest in-service vector
  } vpcStrobes_t;

endpackage

// File: rtl/vpc_prio_enc.sv
// Highest-set-bit search in two levels: per-group index, then group pick.
module vpc_prio_enc #(
  parameter int unsigned NUM_BITS = 256,
  parameter int unsigned GROUP_W  = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_BITS),
  localparam int unsigned GROUPS  = NUM_BITS / GROUP_W,
  localparam int unsigned BIT_W   = $clog2(GROUP_W),
  localparam int unsigned GSEL_W  = $clog2(GROUPS)
) (
  input  logic [NUM_BITS-1:0] bits,
  output logic                any,
  output logic [IDX_W-1:0]    idx
);

  logic [GROUPS-1:0] grpAny;
  logic [BIT_W-1:0]  grpIdx [GROUPS];
  logic [GSEL_W-1:0] grpSel;

  for (genvar g = 0; g < GROUPS; g++) begin : gGroup
    logic [GROUP_W-1:0] slice;
    logic [BIT_W-1:0]   localIdx;

    assign slice     = bits[g*GROUP_W +: GROUP_W];
    assign grpAny[g] = |slice;

    always_comb begin
      localIdx = '0;
      for (int b = 0; b < GROUP_W; b++) begin
        if (slice[b]) localIdx = BIT_W'(b);
      end
    end

    assign grpIdx[g] = localIdx;
  end

  always_comb begin
    grpSel = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (grpAny[g]) grpSel = GSEL_W'(g);
    end
  end

  assign any = |grpAny;
  assign idx = {grpSel, grpIdx[grpSel]};

endmodule

// File: rtl/vpc_datapath.sv
// Vector maps, registered searches, external slot, task priority, spurious reg.
module vpc_datapath
  import vpc_pkg::*;
#(
  parameter int unsigned NUM_VEC = 256,
  parameter int unsigned GROUP_W = 32,
  localparam int unsigned VEC_W  = $clog2(NUM_VEC),
  localparam int unsigned NIB_W  = VEC_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              setValid,
  input  logic [VEC_W-1:0]  setVector,
  input  logic              setLevel,
  input  logic              extValid,
  input  logic [VEC_W-1:0]  extVector,
  input  logic              tprWe,
  input  logic [VEC_W-1:0]  tprData,
  input  logic              tprNibWe,
  input  logic [NIB_W-1:0]  tprNib,
  input  logic              svWe,
  input  logic              svEnable,
  input  logic [VEC_W-1:0]  svVector,
  input  vpcStrobes_t       stb,
  output logic              irrAny,
  output logic [VEC_W-1:0]  irrTop,
  output logic              isrAny,
  output logic [VEC_W-1:0]  isrTop,
  output logic              tmrAtIrr,
  output logic              tmrAtIsr,
  output logic              extPend,
  output logic [VEC_W-1:0]  extPri,
  output logic [VEC_W-1:0]  tpr,
  output logic              swEn,
  output logic [VEC_W-1:0]  spurVec
);

  logic [NUM_VEC-1:0] irrQ, isrQ, tmrQ;
  logic [NUM_VEC-1:0] irrN, isrN, tmrN;
  logic               irrAnyN, isrAnyN;
  logic [VEC_W-1:0]   irrTopN, isrTopN;

  // Next state of the maps; later statements win on a shared vector.
  always_comb begin
    irrN = irrQ;
    isrN = isrQ;
    tmrN = tmrQ;
    if (stb.eoiPop) isrN[isrTop] = 1'b0;
    if (stb.ackLocal) begin
      irrN[irrTop] = 1'b0;
      isrN[irrTop] = 1'b1;
      tmrN[irrTop] = 1'b0;
    end
    if (setValid) begin
      irrN[setVector] = 1'b1;
      tmrN[setVector] = setLevel;
    end
  end

  // Searches run on next state so the registered result never lags the maps.
  vpc_prio_enc #(.NUM_BITS(NUM_VEC), .GROUP_W(GROUP_W)) u_irrEnc (
    .bits(irrN), .any(irrAnyN), .idx(irrTopN)
  );

  vpc_prio_enc #(.NUM_BITS(NUM_VEC), .GROUP_W(GROUP_W)) u_isrEnc (
    .bits(isrN), .any(isrAnyN), .idx(isrTopN)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irrQ   <= '0;
      isrQ   <= '0;
      tmrQ   <= '0;
      irrAny <= 1'b0;
      isrAny <= 1'b0;
      irrTop <= '0;
      isrTop <= '0;
    end else begin
      irrQ   <= irrN;
      isrQ   <= isrN;
      tmrQ   <= tmrN;
      irrAny <= irrAnyN;
      isrAny <= isrAnyN;
      irrTop <= irrTopN;
      isrTop <= isrTopN;
    end
  end

  assign tmrAtIrr = tmrQ[irrTop];
  assign tmrAtIsr = tmrQ[isrTop];

  // External slot: a new fill beats an acknowledge in the same cycle.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extPend <= 1'b0;
      extPri  <= '0;
    end else if (extValid) begin
      extPend <= 1'b1;
      extPri  <= extVector;
    end else if (stb.ackExt) begin
      extPend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tpr <= '0;
    end else if (tprNibWe) begin
      tpr <= {tprNib, {(VEC_W-NIB_W){1'b0}}};
    end else if (tprWe) begin
      tpr <= tprData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swEn    <= 1'b0;
      spurVec <= '1;
    end else if (svWe) begin
      swEn    <= svEnable;
      spurVec <= svVector;
    end
  end

endmodule

// File: rtl/vpc_control.sv
// Eligibility, acknowledge arbitration and the registered result strobes.
module vpc_control
  import vpc_pkg::*;
#(
  parameter int unsigned VEC_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ackReq,
  input  logic              eoiWrite,
  input  logic              globalEn,
  input  logic              irrAny,
  input  logic [VEC_W-1:0]  irrTop,
  input  logic              isrAny,
  input  logic [VEC_W-1:0]  isrTop,
  input  logic              tmrAtIrr,
  input  logic              tmrAtIsr,
  input  logic              extPend,
  input  logic [VEC_W-1:0]  extPri,
  input  logic [VEC_W-1:0]  tpr,
  input  logic              swEn,
  input  logic [VEC_W-1:0]  spurVec,
  output vpcStrobes_t       stb,
  output logic              eligible,
  output logic              irqOut,
  output logic              ackValid,
  output logic [VEC_W-1:0]  ackVector,
  output logic              eoiBcastValid,
  output logic [VEC_W-1:0]  eoiBcastVector,
  output logic              eoiNotifyValid,
  output logic [VEC_W-1:0]  eoiNotifyVector
);

  logic             aboveService;
  logic             localWins;
  logic [VEC_W-1:0] ackPick;

  assign aboveService = !isrAny || (irrTop > isrTop);
  assign eligible     = irrAny && aboveService && (irrTop >= tpr);

  // External slot wins ties and anything above the local vector.
  assign localWins = eligible && (!extPend || (extPri < irrTop));

  always_comb begin
    stb          = '0;
    stb.ackLocal = ackReq && localWins;
    stb.ackExt   = ackReq && !localWins && extPend;
    stb.eoiPop   = eoiWrite && isrAny;
  end

  always_comb begin
    if (localWins)    ackPick = irrTop;
    else if (extPend) ackPick = extPri;
    else              ackPick = spurVec;
  end

  assign irqOut = extPend || (globalEn && swEn && eligible);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ackValid        <= 1'b0;
      ackVector       <= '0;
      eoiBcastValid   <= 1'b0;
      eoiBcastVector  <= '0;
      eoiNotifyValid  <= 1'b0;
      eoiNotifyVector <= '0;
    end else begin
      ackValid       <= ackReq;
      eoiBcastValid  <= stb.ackLocal && tmrAtIrr;
      eoiNotifyValid <= stb.eoiPop && tmrAtIsr;
      if (ackReq) ackVector <= ackPick;
      if (stb.ackLocal) eoiBcastVector <= irrTop;
      if (stb.eoiPop) eoiNotifyVector <= isrTop;
    end
  end

endmodule

// File: rtl/vec_prio_ctrl.sv
module vec_prio_ctrl
  import vpc_pkg::*;
#(
  parameter int unsigned NUM_VEC = 256,
  parameter int unsigned GROUP_W = 32,
  localparam int unsigned VEC_W  = $clog2(NUM_VEC),
  localparam int unsigned NIB_W  = VEC_W / 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             globalEn,
  input  logic             setValid,
  input  logic [VEC_W-1:0] setVector,
  input  logic             setLevel,
  input  logic             extValid,
  input  logic [VEC_W-1:0] extVector,
  input  logic             tprWe,
  input  logic [VEC_W-1:0] tprData,
  input  logic             tprNibWe,
  input  logic [NIB_W-1:0] tprNib,
  output logic [NIB_W-1:0] tprNibOut,
  input  logic             svWe,
  input  logic             svEnable,
  input  logic [VEC_W-1:0] svVector,
  input  logic             ackReq,
  output logic             ackValid,
  output logic [VEC_W-1:0] ackVector,
  input  logic             eoiWrite,
  output logic             irqOut,
  output logic             eoiBcastValid,
  output logic [VEC_W-1:0] eoiBcastVector,
  output logic             eoiNotifyValid,
  output logic [VEC_W-1:0] eoiNotifyVector
);

  vpcStrobes_t      stb;
  logic             irrAny, isrAny, tmrAtIrr, tmrAtIsr, extPend, swEn, eligible;
  logic [VEC_W-1:0] irrTop, isrTop, extPri, tpr, spurVec;

  vpc_datapath #(.NUM_VEC(NUM_VEC), .GROUP_W(GROUP_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .setValid(setValid), .setVector(setVector), .setLevel(setLevel),
    .extValid(extValid), .extVector(extVector),
    .tprWe(tprWe), .tprData(tprData), .tprNibWe(tprNibWe), .tprNib(tprNib),
    .svWe(svWe), .svEnable(svEnable), .svVector(svVector),
    .stb(stb),
    .irrAny(irrAny), .irrTop(irrTop), .isrAny(isrAny), .isrTop(isrTop),
    .tmrAtIrr(tmrAtIrr), .tmrAtIsr(tmrAtIsr),
    .extPend(extPend), .extPri(extPri), .tpr(tpr),
    .swEn(swEn), .spurVec(spurVec)
  );

  vpc_control #(.VEC_W(VEC_W)) u_ctl (
    .clk(clk), .rstN(rstN),
    .ackReq(ackReq), .eoiWrite(eoiWrite), .globalEn(globalEn),
    .irrAny(irrAny), .irrTop(irrTop), .isrAny(isrAny), .isrTop(isrTop),
    .tmrAtIrr(tmrAtIrr), .tmrAtIsr(tmrAtIsr),
    .extPend(extPend), .extPri(extPri), .tpr(tpr),
    .swEn(swEn), .spurVec(spurVec),
    .stb(stb), .eligible(eligible), .irqOut(irqOut),
    .ackValid(ackValid), .ackVector(ackVector),
    .eoiBcastValid(eoiBcastValid), .eoiBcastVector(eoiBcastVector),
    .eoiNotifyValid(eoiNotifyValid), .eoiNotifyVector(eoiNotifyVector)
  );

  assign tprNibOut = tpr[VEC_W-1 -: NIB_W];

endmodule

// File: rtl/vpc_checker.sv
module vpc_checker #(
  parameter int unsigned NIB_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             ackReq,
  input logic             ackValid,
  input logic             eoiWrite,
  input logic             eoiBcastValid,
  input logic             eoiNotifyValid,
  input logic             irqOut,
  input logic             extPend,
  input logic             globalEn,
  input logic             tprNibWe,
  input logic [NIB_W-1:0] tprNib,
  input logic [NIB_W-1:0] tprNibOut
);

  a_r4_ack_follows_req: assert property (@(posedge clk) disable iff (!rstN)
    ackReq |=> ackValid);

  a_r4_no_ack_without_req: assert property (@(posedge clk) disable iff (!rstN)
    !ackReq |=> !ackValid);

  a_r8_bcast_with_ack: assert property (@(posedge clk) disable iff (!rstN)
    eoiBcastValid |-> ackValid);

  a_r9_notify_after_eoi: assert property (@(posedge clk) disable iff (!rstN)
    eoiNotifyValid |-> $past(eoiWrite));

  a_r3_local_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && !extPend) |-> globalEn);

  a_r10_nibble_readback: assert property (@(posedge clk) disable iff (!rstN)
    tprNibWe |=> (tprNibOut == $past(tprNib)));

endmodule

bind vec_prio_ctrl vpc_checker #(.NIB_W(NIB_W)) u_chk (
  .clk(clk), .rstN(rstN), .ackReq(ackReq), .ackValid(ackValid),
  .eoiWrite(eoiWrite), .eoiBcastValid(eoiBcastValid),
  .eoiNotifyValid(eoiNotifyValid), .irqOut(irqOut), .extPend(extPend),
  .globalEn(globalEn), .tprNibWe(tprNibWe), .tprNib(tprNib),
  .tprNibOut(tprNibOut)
);

// File: tb/vec_prio_ctrl_tb.sv
module vec_prio_ctrl_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       globalEn = 1'b1;
  logic       setValid = 1'b0, setLevel = 1'b0;
  logic [7:0] setVector = '0;
  logic       extValid = 1'b0;
  logic [7:0] extVector = '0;
  logic       tprWe = 1'b0, tprNibWe = 1'b0;
  logic [7:0] tprData = '0;
  logic [3:0] tprNib = '0, tprNibOut;
  logic       svWe = 1'b0, svEnable = 1'b0;
  logic [7:0] svVector = '0;
  logic       ackReq = 1'b0, ackValid, eoiWrite = 1'b0, irqOut;
  logic [7:0] ackVector, eoiBcastVector, eoiNotifyVector;
  logic       eoiBcastValid, eoiNotifyValid;

  int nChecks = 0;
  int nFail   = 0;

  always #4 clk = ~clk;

  vec_prio_ctrl u_dut (
    .clk(clk), .rstN(rstN), .globalEn(globalEn),
    .setValid(setValid), .setVector(setVector), .setLevel(setLevel),
    .extValid(extValid), .extVector(extVector),
    .tprWe(tprWe), .tprData(tprData), .tprNibWe(tprNibWe), .tprNib(tprNib),
    .tprNibOut(tprNibOut),
    .svWe(svWe), .svEnable(svEnable), .svVector(svVector),
    .ackReq(ackReq), .ackValid(ackValid), .ackVector(ackVector),
    .eoiWrite(eoiWrite), .irqOut(irqOut),
    .eoiBcastValid(eoiBcastValid), .eoiBcastVector(eoiBcastVector),
    .eoiNotifyValid(eoiNotifyValid), .eoiNotifyVector(eoiNotifyVector)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // All drives at a falling edge; results sampled at the next falling edge.
  task automatic doSet(logic [7:0] v, logic lvl);
    @(negedge clk); setValid = 1'b1; setVector = v; setLevel = lvl;
    @(negedge clk); setValid = 1'b0;
  endtask

  task automatic doExt(logic [7:0] v);
    @(negedge clk); extValid = 1'b1; extVector = v;
    @(negedge clk); extValid = 1'b0;
  endtask

  task automatic doAck(string req, logic [7:0] expVec, logic expBc);
    @(negedge clk); ackReq = 1'b1;
    @(negedge clk); ackReq = 1'b0;
    chk(req, "ackValid", ackValid, 1);
    chk(req, "ackVector", ackVector, expVec);
    chk(req, "eoiBcastValid", eoiBcastValid, expBc);
    if (expBc) chk(req, "eoiBcastVector", eoiBcastVector, expVec);
    @(negedge clk);
    chk("R4", "ackValid drop", ackValid, 0);
  endtask

  task automatic doEoi(string req, logic expNt, logic [7:0] expVec);
    @(negedge clk); eoiWrite = 1'b1;
    @(negedge clk); eoiWrite = 1'b0;
    chk(req, "eoiNotifyValid", eoiNotifyValid, expNt);
    if (expNt) chk(req, "eoiNotifyVector", eoiNotifyVector, expVec);
  endtask

  task automatic chkIrq(string req, logic exp);
    chk(req, "irqOut", irqOut, exp);
  endtask

  task automatic tReset();
    chkIrq("R11", 0);
    chk("R11", "tprNibOut", tprNibOut, 0);
    chk("R11", "eoiBcastValid", eoiBcastValid, 0);
    chk("R11", "ackValid", ackValid, 0);
    doAck("R11", 8'hFF, 0);
  endtask

  task automatic tEnables();
    doSet(8'h40, 0);
    chkIrq("R3", 0);
    doAck("R13", 8'h40, 0);
    doEoi("R13", 0, 8'h00);
    @(negedge clk); svWe = 1'b1; svEnable = 1'b1; svVector = 8'h0F;
    @(negedge clk); svWe = 1'b0;
    chkIrq("R3", 0);
    doSet(8'h40, 0);
    chkIrq("R3", 1);
    @(negedge clk); globalEn = 1'b0;
    @(negedge clk); chkIrq("R3", 0);
    globalEn = 1'b1;
    @(negedge clk); chkIrq("R3", 1);
  endtask

  task automatic tNesting();
    doAck("R7", 8'h40, 0);
    chkIrq("R7", 0);
    doAck("R5", 8'h0F, 0);
    doSet(8'h30, 0);
    chkIrq("R2", 0);
    doSet(8'h50, 0);
    chkIrq("R2", 1);
    doAck("R2", 8'h50, 0);
    doEoi("R9", 0, 8'h00);
    chkIrq("R9", 0);
    doEoi("R9", 0, 8'h00);
    chkIrq("R9", 1);
    doAck("R2", 8'h30, 0);
    doEoi("R9", 0, 8'h00);
    chkIrq("R9", 0);
  endtask

  task automatic tTaskPri();
    @(negedge clk); tprNibWe = 1'b1; tprNib = 4'h5;
    @(negedge clk); tprNibWe = 1'b0;
    chk("R10", "tprNibOut", tprNibOut, 4'h5);
    doSet(8'h4F, 0);
    chkIrq("R10", 0);
    doSet(8'h50, 0);
    chkIrq("R10", 1);
    @(negedge clk); tprWe = 1'b1; tprData = 8'h51;
    @(negedge clk); tprWe = 1'b0;
    chkIrq("R10", 0);
    chk("R10", "tprNibOut", tprNibOut, 4'h5);
    @(negedge clk); tprWe = 1'b1; tprData = 8'h50;
    @(negedge clk); tprWe = 1'b0;
    chkIrq("R10", 1);
    doAck("R10", 8'h50, 0);
    doEoi("R10", 0, 8'h00);
    doAck("R10", 8'h0F, 0);
    @(negedge clk); tprWe = 1'b1; tprData = 8'h00; tprNibWe = 1'b1; tprNib = 4'h0;
    @(negedge clk); tprWe = 1'b0; tprNibWe = 1'b0;
    chkIrq("R10", 1);
    doAck("R10", 8'h4F, 0);
    doEoi("R10", 0, 8'h00);
  endtask

  task automatic tLevel();
    doSet(8'h60, 1);
    doAck("R8", 8'h60, 1);
    doEoi("R8", 0, 8'h00);
    doSet(8'h61, 1);
    doAck("R8", 8'h61, 1);
    doSet(8'h61, 1);
    chkIrq("R2", 0);
    doEoi("R9", 1, 8'h61);
    doAck("R8", 8'h61, 1);
    doEoi("R9", 0, 8'h00);
    doSet(8'h62, 1);
    doSet(8'h62, 0);
    doAck("R1", 8'h62, 0);
    doEoi("R1", 0, 8'h00);
  endtask

  task automatic tExternal();
    @(negedge clk); globalEn = 1'b0;
    doExt(8'h70);
    chkIrq("R3", 1);
    globalEn = 1'b1;
    doSet(8'h70, 0);
    doAck("R6", 8'h70, 0);
    chkIrq("R6", 1);
    doAck("R6", 8'h70, 0);
    chkIrq("R6", 0);
    doAck("R6", 8'h0F, 0);
    doEoi("R6", 0, 8'h00);
    doExt(8'h20);
    doSet(8'h80, 0);
    doAck("R6", 8'h80, 0);
    doAck("R6", 8'h20, 0);
    doAck("R6", 8'h0F, 0);
    doEoi("R6", 0, 8'h00);
    doExt(8'h90);
    doSet(8'h85, 0);
    doAck("R6", 8'h90, 0);
    doAck("R6", 8'h85, 0);
    doEoi("R6", 0, 8'h00);
  endtask

  task automatic tCollide();
    doSet(8'hA0, 0);
    @(negedge clk); ackReq = 1'b1; setValid = 1'b1; setVector = 8'hA0; setLevel = 1'b0;
    @(negedge clk); ackReq = 1'b0; setValid = 1'b0;
    chk("R12", "ackVector", ackVector, 8'hA0);
    chkIrq("R12", 0);
    doEoi("R12", 0, 8'h00);
    chkIrq("R12", 1);
    doAck("R12", 8'hA0, 0);
    doEoi("R12", 0, 8'h00);
  endtask

  task automatic tBoundaries();
    doSet(8'h00, 0);
    chkIrq("R2", 1);
    doAck("R2", 8'h00, 0);
    doEoi("R2", 0, 8'h00);
    doSet(8'h1F, 0);
    doSet(8'h20, 0);
    doAck("R2", 8'h20, 0);
    doAck("R2", 8'h0F, 0);
    doEoi("R2", 0, 8'h00);
    doAck("R2", 8'h1F, 0);
    doEoi("R2", 0, 8'h00);
    doSet(8'hFF, 0);
    doAck("R2", 8'hFF, 0);
    doEoi("R2", 0, 8'h00);
    doEoi("R9", 0, 8'h00);
    chkIrq("R9", 0);
    doSet(8'h10, 0);
    chkIrq("R9", 1);
    doAck("R9", 8'h10, 0);
  endtask

  initial begin
    #(8 * 150000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tEnables();
    tNesting();
    tTaskPri();
    tLevel();
    tExternal();
    tCollide();
    tBoundaries();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule